// File: doc/BRIEF.md
# Biphase-Mark Digital Audio Transmitter with Audio Mute

This block turns a stream of 24-bit stereo PCM samples into a single biphase-mark serial line in the consumer digital audio frame format. A frame holds a left subframe and a right subframe. Each subframe has 32 time slots, and each slot has two line cells. The first four slots of a subframe carry a sync preamble. The following slots carry the audio word, a validity bit, a user bit, one channel-status bit and an even-parity bit. A 192-frame block counter chooses the block-start preamble. It also walks through a 48-bit channel-status image that is copied from a programmable input once per block.

All timing comes from `cellEn`, a one-cycle enable supplied at the line cell rate (128 cells per frame), so one clock domain serves every sample rate from 7 kHz to 216 kHz. The block drives `wordClk` high for the left subframe. On each rising edge of `wordClk` it captures both samples, the validity and user bits and the mute control, so a mute always starts and ends on a frame edge for both channels together. While muted, only the audio field is forced to zero. Preambles, biphase coding, validity, user, channel status and parity keep running.

Top module: `spdifTx`

## Requirements
- R1: While `rstN` is low, `txOut` and `wordClk` are 0. The first `cellEn` after reset emits cell 0 of frame 0 of a block.
- R2: A frame is 128 cells: 64 for the left subframe, then 64 for the right. `wordClk` is 1 during the left cells and 0 during the right cells, and it changes together with `txOut`.
- R3: In slots 4 to 31, the line toggles at the start of every slot. It toggles again at mid-slot when the slot's bit is 1.
- R4: Slots 0 to 3 (8 cells, sent first to last) carry a preamble. The pattern is 11101000 for the left subframe of frame 0 of a block, 11100010 for other left subframes, and 11100100 for right subframes. A pattern is inverted when the line is high just before it starts.
- R5: Slots 4 to 27 carry the 24-bit sample of that subframe, least significant bit in slot 4.
- R6: Slot 28 carries `validIn` and slot 29 carries `userIn`, both as captured at the frame start. Both subframes use the same values.
- R7: In frame n of a block, slot 30 of both subframes carries bit n of the channel-status image for n < 48. It carries 0 for n from 48 to 191.
- R8: Slot 31 carries a bit that makes the number of ones in slots 4 to 31 of the subframe even.
- R9: The channel-status image is copied from `chanStat` only at the start of frame 0 of a block. A change to `chanStat` during a block first shows in the next block.
- R10: When the captured mute is 1, slots 4 to 27 of both subframes are zero. Slots 28 to 30 are unchanged, and the preambles and parity stay correct.
- R11: `leftIn`, `rightIn`, `validIn`, `userIn` and `muteIn` are sampled only on the `cellEn` that emits cell 0 of a frame. Changes at other times have no effect on that frame.
- R12: Without `cellEn`, `txOut` and `wordClk` hold their values and the frame position does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cellEn | input | 1 | One-cycle strobe, one per biphase cell |
| leftIn | input | 24 | Left sample, captured at frame start |
| rightIn | input | 24 | Right sample, captured at frame start |
| validIn | input | 1 | Validity bit for the frame |
| userIn | input | 1 | User bit for the frame |
| muteIn | input | 1 | Audio mute request, captured at frame start |
| chanStat | input | 48 | Channel-status image, bit n sent in frame n |
| txOut | output | 1 | Biphase-mark serial line |
| wordClk | output | 1 | High during the left subframe |

## Verification
Any error in the cell or frame position shows at the ports within one frame. A misplaced cell position corrupts a preamble pattern within 64 cells. A wrong frame counter moves the block-start preamble or the channel-status bit one frame away from where the bench expects it. A stale or early channel-status snapshot, or a mute latched at the wrong time, shows up in slot 30 or in the audio slots of the first affected frame. Because every emitted cell is compared with an encoding built from the requirements, a single wrong bit in any field is reported at the cell where it appears.

// File: rtl/spdifTxPkg.sv
package spdifTxPkg;
  localparam int AUDIO_W    = 24;
  localparam int SLOTS      = 32;
  localparam int CELLS      = 2 * 2 * SLOTS;
  localparam int CELL_W     = $clog2(CELLS);
  localparam int SLOT_W     = $clog2(SLOTS);
  localparam int FIRST_AUD  = 4;
  localparam int SLOT_VALID = FIRST_AUD + AUDIO_W;
  localparam int SLOT_USER  = SLOT_VALID + 1;
  localparam int SLOT_CS    = SLOT_VALID + 2;

  typedef struct packed {
    logic              step;
    logic              load;
    logic              rightSub;
    logic [SLOT_W-1:0] slot;
    logic              secondCell;
    logic              blockStart;
    logic              csBit;
    logic              mute;
  } txStrobe_t;
endpackage

// File: rtl/spdifTxCtrl.sv
module spdifTxCtrl
  import spdifTxPkg::*;
#(
  parameter int FRAMES  = 192,
  parameter int CS_BITS = 48
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cellEn,
  input  logic               muteIn,
  input  logic [CS_BITS-1:0] chanStat,
  output txStrobe_t          strb
);
  localparam int FRAME_W = $clog2(FRAMES);

  logic [CELL_W-1:0]  cellCnt;
  logic [FRAME_W-1:0] frameIdx;
  logic [CS_BITS-1:0] csSnap;
  logic               muteQ;
  logic               frameStart;
  logic               frameEnd;

  assign frameStart = cellEn && (cellCnt == '0);
  assign frameEnd   = cellEn && (cellCnt == CELL_W'(CELLS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cellCnt  <= '0;
      frameIdx <= '0;
      csSnap   <= '0;
      muteQ    <= 1'b0;
    end else if (cellEn) begin
      cellCnt <= cellCnt + 1'b1;
      if (frameStart) begin
        muteQ <= muteIn;
        if (frameIdx == '0) csSnap <= chanStat;
      end
      if (frameEnd) begin
        csSnap   <= csSnap >> 1;
        frameIdx <= (frameIdx == FRAME_W'(FRAMES - 1)) ? '0 : frameIdx + 1'b1;
      end
    end
  end

  assign strb.step       = cellEn;
  assign strb.load       = frameStart;
  assign strb.rightSub   = cellCnt[CELL_W-1];
  assign strb.slot       = cellCnt[CELL_W-2:1];
  assign strb.secondCell = cellCnt[0];
  assign strb.blockStart = (frameIdx == '0);
  assign strb.csBit      = csSnap[0];
  assign strb.mute       = muteQ;

  // R12: position frozen without a cell strobe
  a_r12_position_hold: assert property (@(posedge clk) disable iff (!rstN)
    !cellEn |=> ($stable(cellCnt) && $stable(frameIdx)));
  // R4: block counter stays inside the block length
  a_r4_frame_bound: assert property (@(posedge clk) disable iff (!rstN)
    frameIdx < FRAME_W'(FRAMES));
  // R7: image fully drained once past the programmable range
  a_r7_cs_drained: assert property (@(posedge clk) disable iff (!rstN)
    (frameIdx >= FRAME_W'(CS_BITS)) |-> (csSnap == '0));
endmodule

// File: rtl/spdifTxData.sv
module spdifTxData
  import spdifTxPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  txStrobe_t          strb,
  input  logic [AUDIO_W-1:0] leftIn,
  input  logic [AUDIO_W-1:0] rightIn,
  input  logic               validIn,
  input  logic               userIn,
  output logic               txOut,
  output logic               wordClk
);
  localparam logic [7:0] PAT_BLOCK = 8'b1110_1000;
  localparam logic [7:0] PAT_LEFT  = 8'b1110_0010;
  localparam logic [7:0] PAT_RIGHT = 8'b1110_0100;

  logic [AUDIO_W-1:0] leftQ, rightQ, audio;
  logic               validQ, userQ, polQ, pol, slotBit, parity, nextLvl;
  logic [7:0]         pattern;
  logic [2:0]         preCell;
  logic [SLOT_W-1:0]  audIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      leftQ   <= '0;
      rightQ  <= '0;
      validQ  <= 1'b0;
      userQ   <= 1'b0;
      polQ    <= 1'b0;
      txOut   <= 1'b0;
      wordClk <= 1'b0;
    end else if (strb.step) begin
      if (strb.load) begin
        leftQ  <= leftIn;
        rightQ <= rightIn;
        validQ <= validIn;
        userQ  <= userIn;
      end
      polQ    <= pol;
      txOut   <= nextLvl;
      wordClk <= !strb.rightSub;
    end
  end

  assign audio  = strb.mute ? '0 : (strb.rightSub ? rightQ : leftQ);
  assign audIdx = strb.slot - SLOT_W'(FIRST_AUD);
  assign parity = ^{audio, validQ, userQ, strb.csBit};

  always_comb begin
    if (strb.slot < SLOT_W'(SLOT_VALID))     slotBit = audio[audIdx];
    else if (strb.slot == SLOT_W'(SLOT_VALID)) slotBit = validQ;
    else if (strb.slot == SLOT_W'(SLOT_USER))  slotBit = userQ;
    else if (strb.slot == SLOT_W'(SLOT_CS))    slotBit = strb.csBit;
    else                                       slotBit = parity;
  end

  assign preCell = {strb.slot[1:0], strb.secondCell};
  assign pattern = strb.rightSub ? PAT_RIGHT : (strb.blockStart ? PAT_BLOCK : PAT_LEFT);
  assign pol     = (preCell == 3'd0) ? txOut : polQ;

  always_comb begin
    if (strb.slot < SLOT_W'(FIRST_AUD)) nextLvl = pattern[3'd7 - preCell] ^ pol;
    else if (!strb.secondCell)          nextLvl = !txOut;
    else                                nextLvl = txOut ^ slotBit;
  end

  // R12: line holds between cell strobes
  a_r12_line_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.step |=> ($stable(txOut) && $stable(wordClk)));
  // R3: every data slot opens with a transition
  a_r3_slot_edge: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && strb.slot >= SLOT_W'(FIRST_AUD) && !strb.secondCell) |=> (txOut != $past(txOut)));
  // R10: muted audio slots carry zero
  a_r10_mute_audio: assert property (@(posedge clk) disable iff (!rstN)
    (strb.mute && strb.slot >= SLOT_W'(FIRST_AUD) && strb.slot < SLOT_W'(SLOT_VALID)) |-> !slotBit);
  // R2: word clock high once a frame begins
  a_r2_word_rise: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> wordClk);
endmodule

// File: rtl/spdifTx.sv
module spdifTx
  import spdifTxPkg::*;
#(
  parameter int FRAMES  = 192,
  parameter int CS_BITS = 48
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cellEn,
  input  logic [23:0]        leftIn,
  input  logic [23:0]        rightIn,
  input  logic               validIn,
  input  logic               userIn,
  input  logic               muteIn,
  input  logic [CS_BITS-1:0] chanStat,
  output logic               txOut,
  output logic               wordClk
);
  txStrobe_t strb;

  spdifTxCtrl #(.FRAMES(FRAMES), .CS_BITS(CS_BITS)) uCtrl (
    .clk(clk), .rstN(rstN), .cellEn(cellEn), .muteIn(muteIn),
    .chanStat(chanStat), .strb(strb)
  );

  spdifTxData uData (
    .clk(clk), .rstN(rstN), .strb(strb), .leftIn(leftIn), .rightIn(rightIn),
    .validIn(validIn), .userIn(userIn), .txOut(txOut), .wordClk(wordClk)
  );
endmodule

// File: tb/sim_spdifTx.sv
module sim_spdifTx;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cellEn = 1'b0;
  logic [23:0] leftIn = '0, rightIn = '0;
  logic        validIn = 1'b0, userIn = 1'b0, muteIn = 1'b0;
  logic [47:0] chanStat;
  logic        txOut, wordClk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [47:0] CS_A = 48'h9A3C_5E71_F0D2;
  localparam logic [47:0] CS_B = 48'h1B2D_C4E8_0F67;
  localparam logic [7:0]  P_B = 8'b1110_1000;
  localparam logic [7:0]  P_M = 8'b1110_0010;
  localparam logic [7:0]  P_W = 8'b1110_0100;

  // {left[50:27], right[26:3], mute[2], valid[1], user[0]}
  localparam logic [50:0] VEC [8] = '{
    {24'h000001, 24'h800000, 1'b0, 1'b0, 1'b0},
    {24'hFFFFFF, 24'h000000, 1'b0, 1'b1, 1'b0},
    {24'h5A5A5A, 24'hA5A5A4, 1'b1, 1'b0, 1'b1},
    {24'h123456, 24'h789ABC, 1'b0, 1'b1, 1'b1},
    {24'h000000, 24'hFFFFFF, 1'b0, 1'b0, 1'b1},
    {24'hC0FFEE, 24'h0BADF0, 1'b1, 1'b1, 1'b1},
    {24'h7FFFFF, 24'h800001, 1'b0, 1'b0, 1'b0},
    {24'h3C3C3C, 24'hE1E1E1, 1'b0, 1'b1, 1'b0}
  };

  spdifTx u0 (
    .clk(clk), .rstN(rstN), .cellEn(cellEn), .leftIn(leftIn), .rightIn(rightIn),
    .validIn(validIn), .userIn(userIn), .muteIn(muteIn), .chanStat(chanStat),
    .txOut(txOut), .wordClk(wordClk)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic stepCell();
    @(negedge clk) cellEn = 1'b1;
    @(negedge clk) cellEn = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic lvl, pol;
    logic [47:0] csCur;
    logic [50:0] vec;
    chanStat = CS_A;
    // R1: reset state, cell strobes ignored during reset
    repeat (3) @(negedge clk);
    cellEn = 1'b1;
    @(negedge clk) cellEn = 1'b0;
    check("R1 txOut in reset", txOut, 1'b0);
    check("R1 wordClk in reset", wordClk, 1'b0);
    @(negedge clk) rstN = 1'b1;
    lvl = 1'b0;
    pol = 1'b0;

    for (int blk = 0; blk < 2; blk++) begin
      csCur = (blk == 0) ? CS_A : CS_B;
      for (int f = 0; f < 192; f++) begin
        vec = VEC[(blk * 192 + f) % 8];
        if (blk == 0 && f == 100) chanStat = CS_B;  // R9: not used until block 1
        for (int c = 0; c < 128; c++) begin
          int sub, pos, k, h;
          logic [23:0] aud;
          logic bitv, mute, valid, user, cs;
          logic [7:0] pat;
          string tag;
          if (c == 0) begin
            leftIn  = vec[50:27];
            rightIn = vec[26:3];
            muteIn  = vec[2];
            validIn = vec[1];
            userIn  = vec[0];
          end
          if (c == 40) begin
            // R11: mid-frame changes must not reach this frame
            muteIn  = ~muteIn;
            leftIn  = ~leftIn;
            rightIn = rightIn ^ 24'h00F00F;
            validIn = ~validIn;
            userIn  = ~userIn;
          end
          stepCell();
          sub = c / 64; pos = c % 64; k = pos / 2; h = pos % 2;
          mute = vec[2]; valid = vec[1]; user = vec[0];
          aud = mute ? 24'h0 : (sub == 1 ? vec[26:3] : vec[50:27]);
          cs = (f < 48) ? csCur[f] : 1'b0;
          if (k >= 4 && k < 28) begin
            bitv = aud[k-4];
            tag = mute ? "R10/R11 audio" : "R3/R5/R11 audio";
          end else if (k == 28) begin bitv = valid; tag = "R6 validity"; end
          else if (k == 29) begin bitv = user; tag = "R6 user"; end
          else if (k == 30) begin bitv = cs; tag = "R7/R9 chanstat"; end
          else begin
            bitv = ^{aud, valid, user, cs};
            tag = "R8 parity";
          end
          if (k < 4) begin
            if (pos == 0) pol = lvl;
            pat = (sub == 1) ? P_W : ((f == 0) ? P_B : P_M);
            lvl = pat[7-pos] ^ pol;
            tag = "R4 preamble";
          end else if (h == 0) lvl = ~lvl;
          else if (bitv) lvl = ~lvl;
          check(tag, txOut, lvl);
          check("R2 wordClk", wordClk, (sub == 0));
          if (c % 23 == 5) begin
            // R12: idle cycles leave the line untouched
            repeat (3) @(negedge clk);
            check("R12 hold txOut", txOut, lvl);
            check("R12 hold wordClk", wordClk, (sub == 0));
          end
        end
      end
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule